// File: doc/BRIEF.md
# PRBS-7 Word Injector and Checker

This block sits between a line encoder and a serializer on a transmit path that moves 20-bit words. A seven-stage linear feedback shift register produces a repeating 127-bit pseudorandom pattern. It advances twenty bit positions on every word clock. While the test input is high, this pattern replaces the encoded word bound for the serializer, and the encoded input is disregarded. When the test input drops, encoded words flow through again from the next word on. The generator freezes while idle and resumes where it stopped, so the pattern seen on the line is the same every time.

A companion checker takes received words, for example from a loopback. It loads its history from the incoming bits and then predicts each following bit from the recurrence. Each mismatched bit adds one to a saturating error counter. A lock flag is raised after a configurable run of clean words. The checker synchronizes itself on any pattern phase, so it needs no seed agreement with the transmitter.

Top module: `prbs7_inject_top`

## Requirements
- R1: Under reset, `ser_word` is zero, `err_cnt` is zero and `chk_lock` is low. The generator starts from the all-ones state, so the first injected word carries bits b0..b19 of the sequence b[n] = b[n-7] XOR b[n-6], where b[-7..-1] = 1.
- R2: The generator never reaches the all-zero state. With the test held high, the injected word sequence repeats every 127 words.
- R3: When `test_en` is high at a clock edge, `ser_word` after that edge holds the next 20 pattern bits, with the oldest bit in bit 0.
- R4: When `test_en` is low at a clock edge, `ser_word` after that edge equals `enc_word` at that edge. While `test_en` is high, the value of `enc_word` has no effect on `ser_word`.
- R5: While `test_en` is low the generator holds its state. When the test is re-enabled, the pattern continues from the bit after the last one sent, with no reseed.
- R6: The first word taken with `chk_en` high, after reset or after `chk_en` was low, only loads the checker history and adds no errors. Stale history from earlier words is never scored.
- R7: After priming, each received bit is compared with the XOR of the received bits 7 and 6 positions earlier, and every mismatch adds one to `err_cnt`. A single flipped bit therefore adds exactly 3.
- R8: `err_cnt` saturates at 2^ERR_W-1 and never wraps or decreases while reset is inactive.
- R9: `chk_lock` rises after LOCK_WORDS consecutive scored words without error. It falls after any word with a mismatch and whenever `chk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Selects the pattern instead of encoded data |
| enc_word | input | W (20) | Encoded word from the line encoder |
| ser_word | output | W (20) | Registered word to the serializer, bit 0 sent first |
| chk_en | input | 1 | Enables the pattern checker |
| rx_word | input | W (20) | Received word to be checked, bit 0 oldest |
| err_cnt | output | ERR_W (8) | Saturating count of mismatched bits |
| chk_lock | output | 1 | Clean-run lock flag |

## Verification
Two situations are hardest to reach from the ports. One is a corrupted bit near a word boundary, where its three mismatches are split across two words. The other is the checker re-priming over stale history after the test input was toggled. The stimulus loops the output back through an XOR mask, so single-bit flips can be placed at random positions. Test bursts are randomly gated, and the checker enable follows the previous cycle's test state, so the checker re-primes on every burst. A final run feeds inverted words to push the counter into saturation.

// File: rtl/prbs7_pkg.sv
`timescale 1ns/1ps
package prbs7_pkg;
   localparam int ORDER  = 7;
   localparam int TAP_HI = 7;
   localparam int TAP_LO = 6;

   typedef logic [ORDER-1:0] lfsr_t;

   localparam lfsr_t SEED = '1;

   // feedback for x^7 + x^6 + 1: newest bit = bit 7 back XOR bit 6 back
   function automatic logic fb_bit(lfsr_t s);
      return s[TAP_HI-1] ^ s[TAP_LO-1];
   endfunction

   function automatic lfsr_t shift_in(lfsr_t s, logic b);
      return {s[ORDER-2:0], b};
   endfunction
endpackage

// File: rtl/prbs7_gen.sv
`timescale 1ns/1ps
module prbs7_gen
   import prbs7_pkg::*;
#(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] word_o,
   output lfsr_t        state_o
);
   lfsr_t st_q;
   lfsr_t st_nx;

   always_comb begin
      lfsr_t s;
      s      = st_q;
      word_o = '0;
      for (int i = 0; i < W; i++) begin
         word_o[i] = fb_bit(s);
         s         = shift_in(s, word_o[i]);
      end
      st_nx = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= SEED;
      else if (adv) st_q <= st_nx;
   end

   assign state_o = st_q;
endmodule

// File: rtl/prbs7_sel.sv
`timescale 1ns/1ps
module prbs7_sel #(
   parameter int W       = 20,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel,
   input  logic [W-1:0] prbs_word,
   input  logic [W-1:0] data_word,
   output logic [W-1:0] out_word
);
   logic [W-1:0] pick;

   assign pick = sel ? prbs_word : data_word;

   generate
      if (OUT_REG) begin : g_reg
         logic [W-1:0] out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= pick;
         end
         assign out_word = out_q;
      end else begin : g_comb
         assign out_word = rst_n ? pick : '0;
      end
   endgenerate
endmodule

// File: rtl/prbs7_chk.sv
`timescale 1ns/1ps
module prbs7_chk
   import prbs7_pkg::*;
#(
   parameter int W          = 20,
   parameter int ERR_W      = 8,
   parameter int LOCK_WORDS = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [W-1:0]     rx_word,
   output logic [ERR_W-1:0] err_cnt,
   output logic             lock,
   output logic             mis_any_o
);
   localparam int CW    = $clog2(W + 1);
   localparam int SW    = ((ERR_W > CW) ? ERR_W : CW) + 1;
   localparam int RUN_W = $clog2(LOCK_WORDS + 1);

   lfsr_t            hist_q, hist_nx;
   logic             primed_q;
   logic [W-1:0]     mis;
   logic [CW-1:0]    nmis;
   logic [SW-1:0]    sum;
   logic [ERR_W-1:0] err_q, err_sat;
   logic [RUN_W-1:0] run_q, run_nx;
   logic             lock_q;

   always_comb begin
      lfsr_t s;
      s    = hist_q;
      mis  = '0;
      nmis = '0;
      for (int i = 0; i < W; i++) begin
         mis[i] = rx_word[i] ^ fb_bit(s);
         nmis   = nmis + CW'(mis[i]);
         s      = shift_in(s, rx_word[i]);
      end
      hist_nx = s;
   end

   assign sum     = SW'(err_q) + SW'(nmis);
   assign err_sat = (sum > SW'({ERR_W{1'b1}})) ? {ERR_W{1'b1}} : sum[ERR_W-1:0];
   assign run_nx  = (run_q == RUN_W'(LOCK_WORDS)) ? run_q : run_q + RUN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q   <= SEED;
         primed_q <= 1'b0;
         err_q    <= '0;
         run_q    <= '0;
         lock_q   <= 1'b0;
      end else begin
         hist_q <= hist_nx;
         if (!en) begin
            primed_q <= 1'b0;
            run_q    <= '0;
            lock_q   <= 1'b0;
         end else if (!primed_q) begin
            primed_q <= 1'b1;
         end else begin
            err_q <= err_sat;
            if (nmis != '0) begin
               run_q  <= '0;
               lock_q <= 1'b0;
            end else begin
               run_q  <= run_nx;
               lock_q <= (run_nx == RUN_W'(LOCK_WORDS));
            end
         end
      end
   end

   assign err_cnt   = err_q;
   assign lock      = lock_q;
   assign mis_any_o = en & primed_q & (|mis);
endmodule

// File: rtl/prbs7_inject_top.sv
`timescale 1ns/1ps
module prbs7_inject_top
   import prbs7_pkg::*;
#(
   parameter int W          = 20,
   parameter int ERR_W      = 8,
   parameter int LOCK_WORDS = 20,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             test_en,
   input  logic [W-1:0]     enc_word,
   output logic [W-1:0]     ser_word,
   input  logic             chk_en,
   input  logic [W-1:0]     rx_word,
   output logic [ERR_W-1:0] err_cnt,
   output logic             chk_lock
);
   generate
      if (W < ORDER) begin : g_bad_w
         $error("word width must cover the generator order");
      end
      if (ERR_W < 1) begin : g_bad_e
         $error("error counter needs at least one bit");
      end
      if (LOCK_WORDS < 1) begin : g_bad_l
         $error("lock run must be at least one word");
      end
   endgenerate

   logic [W-1:0] gen_word;
   lfsr_t        gen_state;
   logic         chk_mis_any;

   prbs7_gen #(.W(W)) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (test_en),
      .word_o  (gen_word),
      .state_o (gen_state)
   );

   prbs7_sel #(.W(W), .OUT_REG(OUT_REG)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (test_en),
      .prbs_word (gen_word),
      .data_word (enc_word),
      .out_word  (ser_word)
   );

   prbs7_chk #(.W(W), .ERR_W(ERR_W), .LOCK_WORDS(LOCK_WORDS)) u_chk (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (chk_en),
      .rx_word   (rx_word),
      .err_cnt   (err_cnt),
      .lock      (chk_lock),
      .mis_any_o (chk_mis_any)
   );
endmodule

// File: rtl/prbs7_inject_sva.sv
`timescale 1ns/1ps
module prbs7_inject_sva #(
   parameter int W       = 20,
   parameter int ERR_W   = 8,
   parameter int ORD     = 7,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             test_en,
   input logic [W-1:0]     enc_word,
   input logic [W-1:0]     ser_word,
   input logic [W-1:0]     gen_word,
   input logic [ORD-1:0]   gen_state,
   input logic             chk_en,
   input logic             chk_mis_any,
   input logic [ERR_W-1:0] err_cnt,
   input logic             chk_lock
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      gen_state != '0); // R2

   generate
      if (OUT_REG) begin : g_reg_checks
         AST_SER_PRBS: assert property (@(posedge clk) disable iff (!rst_n)
            armed && $past(test_en) |-> ser_word == $past(gen_word)); // R3
         AST_SER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            armed && !$past(test_en) |-> ser_word == $past(enc_word)); // R4
      end
   endgenerate

   AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(test_en) |-> gen_state == $past(gen_state)); // R5

   AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(chk_en) |-> err_cnt == $past(err_cnt)); // R6

   AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> err_cnt >= $past(err_cnt)); // R8

   AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      armed && ($past(chk_mis_any) || !$past(chk_en)) |-> !chk_lock); // R9
endmodule

bind prbs7_inject_top prbs7_inject_sva #(
   .W(W), .ERR_W(ERR_W), .ORD(prbs7_pkg::ORDER), .OUT_REG(OUT_REG)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .test_en     (test_en),
   .enc_word    (enc_word),
   .ser_word    (ser_word),
   .gen_word    (gen_word),
   .gen_state   (gen_state),
   .chk_en      (chk_en),
   .chk_mis_any (chk_mis_any),
   .err_cnt     (err_cnt),
   .chk_lock    (chk_lock)
);

// File: tb/tb_prbs7_inject_top.sv
`timescale 1ns/1ps
module tb_prbs7_inject_top;
   localparam int W       = 20;
   localparam int ERR_W   = 8;
   localparam int LOCKW   = 20;
   localparam int ERR_MAX = (1 << ERR_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             test_en;
   logic [W-1:0]     enc_word;
   logic [W-1:0]     ser_word;
   logic             chk_en;
   logic [W-1:0]     rx_word;
   logic [W-1:0]     flip;
   logic [ERR_W-1:0] err_cnt;
   logic             chk_lock;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   assign rx_word = ser_word ^ flip;

   prbs7_inject_top #(.W(W), .ERR_W(ERR_W), .LOCK_WORDS(LOCKW)) dut (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .enc_word(enc_word),
      .ser_word(ser_word), .chk_en(chk_en), .rx_word(rx_word),
      .err_cnt(err_cnt), .chk_lock(chk_lock)
   );

   // reference pattern: one full period built from the recurrence
   bit seq [0:126];
   int gp = 0;
   // checker model: rh[0] is the oldest of the last seven received bits
   bit rh [0:6];
   bit m_primed = 0;
   int m_run    = 0;
   bit m_lock   = 0;
   int m_err    = 0;
   logic [W-1:0] last_es;

   function automatic void build_seq();
      bit ext [0:133];
      for (int k = 0; k < 7; k++) ext[k] = 1'b1;
      for (int k = 7; k < 134; k++) ext[k] = ext[k-7] ^ ext[k-6];
      for (int n = 0; n < 127; n++) seq[n] = ext[n+7];
   endfunction

   function automatic logic [W-1:0] model_word();
      logic [W-1:0] w;
      for (int i = 0; i < W; i++) w[i] = seq[(gp + i) % 127];
      gp = (gp + W) % 127;
      return w;
   endfunction

   function automatic void model_chk(logic [W-1:0] rxw, bit en);
      int nm = 0;
      bit score;
      score = en && m_primed;
      for (int i = 0; i < W; i++) begin
         if (score && (rxw[i] != (rh[0] ^ rh[1]))) nm++;
         for (int k = 0; k < 6; k++) rh[k] = rh[k+1];
         rh[6] = rxw[i];
      end
      if (!en) begin
         m_primed = 0; m_run = 0; m_lock = 0;
      end else if (!m_primed) begin
         m_primed = 1;
      end else begin
         m_err = (m_err + nm > ERR_MAX) ? ERR_MAX : m_err + nm;
         if (nm != 0) begin
            m_run = 0; m_lock = 0;
         end else begin
            if (m_run < LOCKW) m_run++;
            m_lock = (m_run == LOCKW);
         end
      end
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   task automatic cycle();
      logic [W-1:0] rxw;
      rxw = ser_word ^ flip;
      if (test_en) last_es = model_word();
      else         last_es = enc_word;
      model_chk(rxw, chk_en);
      @(posedge clk);
      #1;
      chk("R3/R4 ser_word", ser_word, last_es);
      chk("R7 err_cnt", err_cnt, m_err);
      chk("R9 chk_lock", chk_lock, m_lock);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [W-1:0] first;
      int unsigned  dummy;
      int           e0;
      bit           prev;
      dummy = $urandom(32'd4242);
      build_seq();
      for (int k = 0; k < 7; k++) rh[k] = 1'b1;
      rst_n = 0; test_en = 0; chk_en = 0; enc_word = '0; flip = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset ser_word", ser_word, 0);
      chk("R1 reset err_cnt", err_cnt, 0);
      chk("R1 reset lock", chk_lock, 0);

      // first word from the all-ones seed
      for (int i = 0; i < W; i++) first[i] = seq[i];
      rst_n = 1; test_en = 1; enc_word = W'($urandom);
      cycle();
      chk("R1 first word", ser_word, first);

      // R4: enc_word changes every cycle but must not leak; lock timing R9
      chk_en = 1;
      for (int j = 1; j <= 127; j++) begin
         enc_word = W'($urandom);
         cycle();
         if (j == 1)  chk("R6 prime adds nothing", err_cnt, 0);
         if (j == 20) chk("R9 not yet locked", chk_lock, 0);
         if (j == 21) chk("R9 locked", chk_lock, 1);
      end
      chk("R2 period 127 words", ser_word, first);

      // R7: single flipped bit gives three mismatches
      e0 = int'(err_cnt);
      flip = W'(1) << ($urandom % W);
      cycle();
      flip = '0;
      cycle();
      cycle();
      chk("R7 single flip", err_cnt, e0 + 3);

      // R5: pause, pass data, resume without reseed
      test_en = 0; chk_en = 0;
      repeat (5) begin
         enc_word = W'($urandom);
         cycle();
      end
      test_en = 1;
      cycle();
      chk("R5 resume continues", ser_word, last_es);
      e0 = int'(err_cnt);
      chk_en = 1;
      cycle();
      chk("R6 stale history ignored", err_cnt, e0);

      // random bursts; checker follows previous cycle's test state
      prev = 1;
      for (int r = 0; r < 2000; r++) begin
         bit te;
         te       = ($urandom % 10) < 7;
         test_en  = te;
         chk_en   = prev;
         enc_word = W'($urandom);
         flip     = (($urandom % 100) == 0) ? (W'(1) << ($urandom % W)) : '0;
         cycle();
         prev = te;
      end
      flip = '0;

      // R8: saturation with inverted words
      test_en = 1; chk_en = 0;
      cycle();
      chk_en = 1;
      repeat (25) cycle();
      flip = '1;
      repeat (16) cycle();
      chk("R8 saturated", err_cnt, ERR_MAX);
      repeat (3) cycle();
      chk("R8 stays saturated", err_cnt, ERR_MAX);
      flip = '0;
      cycle();

      summary();
      $finish;
   end
endmodule